// File: doc/BRIEF.md
# Multi-Channel Interrupt Cause Aggregator

This block gathers interrupt events from up to eight channels into one level-sensitive interrupt line. The channels form two host groups of four. Each group keeps a cause register with one engine-completion flag and one device-interrupt flag per channel. Each channel also keeps an error cause register and an error mask. A read-only main cause word summarises all of this per channel. A main mask selects which summary bits may raise the interrupt output.

Event sources are single-cycle input pulses. Software reaches every register through a simple word-wide port that has a write strobe and combinational read data. The group cause and error cause registers clear when software writes 0 to a bit. A write of 1 leaves that bit untouched. Firmware can therefore acknowledge exactly the bits it has serviced without racing against new events.

Top module: `irq_cause_agg`

## Requirements
- R1: After reset every cause register, every error mask, the main mask and `irq` are 0.
- R2: A pulse on `done_evt[n]` sets bit n mod 4 of the cause register of group n/4 (address 2 + n/4). A pulse on `dev_evt[n]` sets bit 8 + n mod 4 of that register. All other bits of a group cause register read 0.
- R3: A write to a group cause register clears each defined bit written as 0 and leaves each bit written as 1 unchanged. Without a write, no bit of the register clears.
- R4: When an event and a write that clears its bit land in the same cycle, the bit ends up set.
- R5: Main cause (address 0) places the summary bit of channel n at 2n for n < 4 and at 2n + 1 for n >= 4, and the device bit one position above it. Bit 8 and bits 17 and up read 0.
- R6: The error cause register of channel n (address 8 + n, 8 bits) latches bit k when bit k of `err_evt[8n+7:8n]` pulses. Writing 0 to a bit clears it, so an all-zero write clears the register. An event in the same cycle as the clear wins.
- R7: The error mask of channel n (address 16 + n) resets to 0 and reads back as written. An all-ones write unmasks every error source. The summary bit of channel n is set when its group completion bit is set or any error cause bit is set with its mask bit.
- R8: The main mask (address 1, 32 bits, read/write) resets to 0. `irq` is 1 only if some main cause bit and its main mask bit are both 1.
- R9: `irq` is registered. It reflects the cause and mask state of the previous cycle, so it changes one cycle after that state changes.
- R10: Writes to address 0 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_evt | input | 8 | Engine-completion pulse, one per channel |
| dev_evt | input | 8 | Device interrupt pulse, one per channel |
| err_evt | input | 64 | Error source pulses, 8 per channel, channel n at [8n+7:8n] |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Registered interrupt output |

## Verification
A bad latch or clear in a cause register shows up at once on the read port in the cycle after the edge. One edge later it shows up on `irq` if the matching main mask bit is set. A wrong bit position in the main cause mapping is invisible on the group registers. It only appears when the main cause word and `irq` are read under a sparse mask, so the bench reads every register after every clock edge. A lost event in a same-cycle clear race reads back as 0 right after that edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Position of the summary bit of channel ch in the main cause word.
  // Each group of grp channels occupies 2*grp bits, and groups after
  // the first are shifted up by one more bit each, leaving a gap.
  function automatic int sum_pos(input int ch, input int grp);
    return 2 * ch + ch / grp;
  endfunction

  // Device-activity bit sits right above the summary bit.
  function automatic int dev_pos(input int ch, input int grp);
    return sum_pos(ch, grp) + 1;
  endfunction

  // Highest main cause bit in use, for width sanity checks.
  function automatic int top_pos(input int nch, input int grp);
    return dev_pos(nch - 1, grp);
  endfunction

endpackage

// File: rtl/irq_grp_cause.sv
module irq_grp_cause #(
  parameter int GRP     = 4,
  parameter int DW      = 32,
  parameter int DEV_OFS = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [GRP-1:0] keep_done,
  input  logic [GRP-1:0] keep_dev,
  input  logic [GRP-1:0] done_evt,
  input  logic [GRP-1:0] dev_evt,
  output logic [GRP-1:0] done_q,
  output logic [GRP-1:0] dev_q,
  output logic [DW-1:0]  rd_word
);

  logic [GRP-1:0] done_mask_w, dev_mask_w;

  // A write holds only the bits written as 1; events OR in afterwards.
  assign done_mask_w = wr_en ? keep_done : '1;
  assign dev_mask_w  = wr_en ? keep_dev  : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
      dev_q  <= '0;
    end else begin
      done_q <= (done_q & done_mask_w) | done_evt;
      dev_q  <= (dev_q & dev_mask_w) | dev_evt;
    end
  end

  always_comb begin
    rd_word = '0;
    rd_word[GRP-1:0]       = done_q;
    rd_word[DEV_OFS +: GRP] = dev_q;
  end

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_evt) |=> ((done_q & $past(done_evt)) == $past(done_evt)));

  p_no_loss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (($past(done_q) & ~done_q) == '0 && ($past(dev_q) & ~dev_q) == '0));

  p_zero_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((done_q & ~$past(keep_done) & ~$past(done_evt)) == '0));

  p_evt_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && |dev_evt) |=> ((dev_q & $past(dev_evt)) == $past(dev_evt)));

endmodule

// File: rtl/irq_err_chan.sv
module irq_err_chan #(
  parameter int ERRW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cause_wr,
  input  logic            mask_wr,
  input  logic [ERRW-1:0] wdata,
  input  logic [ERRW-1:0] evt,
  output logic [ERRW-1:0] cause_q,
  output logic [ERRW-1:0] mask_q,
  output logic            err_sum
);

  logic [ERRW-1:0] keep_w;

  assign keep_w = cause_wr ? wdata : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= (cause_q & keep_w) | evt;
      if (mask_wr) mask_q <= wdata;
    end
  end

  assign err_sum = |(cause_q & mask_q);

  p_err_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((cause_q & $past(evt)) == $past(evt)));

  p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_wr && wdata == '0 && evt == '0) |=> (cause_q == '0));

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));

endmodule

// File: rtl/irq_main_map.sv
module irq_main_map
  import irq_agg_pkg::*;
#(
  parameter int NCH = 8,
  parameter int GRP = 4,
  parameter int DW  = 32
) (
  input  logic [NCH-1:0] sum_bits,
  input  logic [NCH-1:0] dev_bits,
  output logic [DW-1:0]  cause_word
);

  localparam int TOP = top_pos(NCH, GRP);

  always_comb begin
    cause_word = '0;
    for (int n = 0; n < NCH; n++) begin
      cause_word[sum_pos(n, GRP)] = sum_bits[n];
      cause_word[dev_pos(n, GRP)] = dev_bits[n];
    end
  end

  initial begin
    a_fits_r5: assert (TOP < DW) else $error("main cause map exceeds word");
  end

endmodule

// File: rtl/irq_cause_agg.sv
module irq_cause_agg
  import irq_agg_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int GRP     = 4,
  parameter int ERRW    = 8,
  parameter int DW      = 32,
  parameter int AW      = 5,
  parameter int DEV_OFS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     done_evt,
  input  logic [NCH-1:0]     dev_evt,
  input  logic [NCH*ERRW-1:0] err_evt,
  input  logic               reg_we,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic               irq
);

  localparam int NGRP     = NCH / GRP;
  localparam int A_MAIN   = 0;
  localparam int A_MASK   = 1;
  localparam int A_GRP    = 2;
  localparam int A_ECAUSE = 8;
  localparam int A_EMASK  = 16;

  logic [NCH-1:0]  done_all, dev_all, err_sum_all, sum_all;
  logic [DW-1:0]   grp_word [NGRP];
  logic [ERRW-1:0] ecause [NCH];
  logic [ERRW-1:0] emask  [NCH];
  logic [DW-1:0]   main_cause, main_mask;
  logic            hit_w;

  // Host groups
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic wr_g;
    assign wr_g = reg_we && (reg_addr == AW'(A_GRP + g));
    irq_grp_cause #(.GRP(GRP), .DW(DW), .DEV_OFS(DEV_OFS)) u_grp (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_g),
      .keep_done (reg_wdata[GRP-1:0]),
      .keep_dev  (reg_wdata[DEV_OFS +: GRP]),
      .done_evt  (done_evt[g*GRP +: GRP]),
      .dev_evt   (dev_evt[g*GRP +: GRP]),
      .done_q    (done_all[g*GRP +: GRP]),
      .dev_q     (dev_all[g*GRP +: GRP]),
      .rd_word   (grp_word[g])
    );
  end

  // Per-channel error cause and mask
  for (genvar n = 0; n < NCH; n++) begin : g_err
    logic cwr, mwr;
    assign cwr = reg_we && (reg_addr == AW'(A_ECAUSE + n));
    assign mwr = reg_we && (reg_addr == AW'(A_EMASK + n));
    irq_err_chan #(.ERRW(ERRW)) u_err (
      .clk      (clk),
      .rst_n    (rst_n),
      .cause_wr (cwr),
      .mask_wr  (mwr),
      .wdata    (reg_wdata[ERRW-1:0]),
      .evt      (err_evt[n*ERRW +: ERRW]),
      .cause_q  (ecause[n]),
      .mask_q   (emask[n]),
      .err_sum  (err_sum_all[n])
    );
  end

  assign sum_all = done_all | err_sum_all;

  irq_main_map #(.NCH(NCH), .GRP(GRP), .DW(DW)) u_map (
    .sum_bits   (sum_all),
    .dev_bits   (dev_all),
    .cause_word (main_cause)
  );

  assign hit_w = |(main_cause & main_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_mask <= '0;
      irq       <= 1'b0;
    end else begin
      if (reg_we && reg_addr == AW'(A_MASK)) main_mask <= reg_wdata;
      irq <= hit_w;
    end
  end

  // Readback
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(A_MAIN)) reg_rdata = main_cause;
    if (reg_addr == AW'(A_MASK)) reg_rdata = main_mask;
    for (int g = 0; g < NGRP; g++)
      if (reg_addr == AW'(A_GRP + g)) reg_rdata = grp_word[g];
    for (int n = 0; n < NCH; n++) begin
      if (reg_addr == AW'(A_ECAUSE + n)) reg_rdata = DW'(ecause[n]);
      if (reg_addr == AW'(A_EMASK + n))  reg_rdata = DW'(emask[n]);
    end
  end

  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (main_mask == '0) |=> !irq);

  p_irq_needs_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(main_cause) != '0 && $past(main_mask) != '0));

  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(A_MAIN)) |=> $stable(main_mask));

endmodule

// File: tb/irq_cause_agg_tb.sv
`timescale 1ns/100ps
module irq_cause_agg_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  done_evt = '0, dev_evt = '0;
  logic [63:0] err_evt = '0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int errors = 0, checks = 0;
  bit finished = 0;

  // reference state
  logic [31:0] m_grp [2];
  logic [7:0]  m_ec [8];
  logic [7:0]  m_em [8];
  logic [31:0] m_mm;
  logic        m_irq;

  always #5 clk = ~clk;

  irq_cause_agg u_dut (
    .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .dev_evt(dev_evt),
    .err_evt(err_evt), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [31:0] exp_main();
    logic [31:0] w = '0;
    for (int n = 0; n < 8; n++) begin
      int p = (n < 4) ? 2 * n : 2 * n + 1;
      w[p]   = m_grp[n / 4][n % 4] | (|(m_ec[n] & m_em[n]));
      w[p+1] = m_grp[n / 4][8 + n % 4];
    end
    return w;
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    if (a == 0) return exp_main();
    if (a == 1) return m_mm;
    if (a == 2 || a == 3) return m_grp[a - 2];
    if (a >= 8 && a < 16) return {24'h0, m_ec[a - 8]};
    if (a >= 16 && a < 24) return {24'h0, m_em[a - 16]};
    return 32'h0;
  endfunction

  function automatic string tag_of(input int a);
    if (a == 0) return "R5";
    if (a == 1) return "R8";
    if (a == 2 || a == 3) return "R3";
    if (a >= 8 && a < 16) return "R6";
    if (a >= 16 && a < 24) return "R7";
    return "R10";
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_grp[0] = '0; m_grp[1] = '0; m_mm = '0; m_irq = 1'b0;
    for (int n = 0; n < 8; n++) begin m_ec[n] = '0; m_em[n] = '0; end
  endtask

  // advance the model by one edge using the inputs now driven
  task automatic model_step();
    logic [31:0] keep;
    m_irq = |(exp_main() & m_mm);
    for (int g = 0; g < 2; g++) begin
      keep = (reg_we && reg_addr == 5'(2 + g)) ? reg_wdata : 32'hFFFF_FFFF;
      m_grp[g] = m_grp[g] & keep & 32'h0000_0F0F;
      for (int i = 0; i < 4; i++) begin
        if (done_evt[4*g+i]) m_grp[g][i] = 1'b1;
        if (dev_evt[4*g+i])  m_grp[g][8+i] = 1'b1;
      end
    end
    for (int n = 0; n < 8; n++) begin
      if (reg_we && reg_addr == 5'(8 + n)) m_ec[n] = m_ec[n] & reg_wdata[7:0];
      m_ec[n] = m_ec[n] | err_evt[8*n +: 8];
      if (reg_we && reg_addr == 5'(16 + n)) m_em[n] = reg_wdata[7:0];
    end
    if (reg_we && reg_addr == 5'd1) m_mm = reg_wdata;
  endtask

  task automatic scan();
    chk("R9 irq", {31'h0, irq}, {31'h0, m_irq});
    for (int a = 0; a < 24; a++) begin
      reg_addr = 5'(a);
      #0.2;
      chk(tag_of(a), reg_rdata, exp_read(a));
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    #1;
    reg_we = 1'b0; done_evt = '0; dev_evt = '0; err_evt = '0;
    scan();
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = 5'(a); #0.2; d = reg_rdata;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    model_reset();
    #23 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    chk("R1 irq", {31'h0, irq}, 32'h0);
    for (int a = 0; a < 24; a++) begin rd(a, d); chk("R1 reg", d, 32'h0); end

    // R2: completion on ch2, masked -> no irq (R8)
    done_evt[2] = 1'b1; tick();
    rd(2, d); chk("R2 done ch2", d, 32'h0000_0004);
    tick(); chk("R8 masked irq", {31'h0, irq}, 32'h0);

    // R9: unmask summary of ch2 (bit 4); irq one edge after the mask
    wr(1, 32'h0000_0010); tick();
    chk("R9 not yet", {31'h0, irq}, 32'h0);
    tick(); chk("R9 asserted", {31'h0, irq}, 32'h1);

    // R2/R5: device event ch5 -> group1 bit 9, main bit 12
    dev_evt[5] = 1'b1; tick();
    rd(3, d); chk("R2 dev ch5", d, 32'h0000_0200);
    rd(0, d); chk("R5 map ch5", d, 32'h0000_1010);

    // R5: ch4 summary at bit 9, ch7 device at bit 16, bit 8 gap
    done_evt[4] = 1'b1; dev_evt[7] = 1'b1; done_evt[3] = 1'b1; tick();
    rd(0, d); chk("R5 gap", d, 32'h0001_1250);

    // R3: clear only ch2 completion, writing ones elsewhere
    wr(2, 32'hFFFF_FFFB); tick();
    rd(2, d); chk("R3 w0c", d, 32'h0000_0008);

    // R4: event on ch1 during a clear-all write of group0
    done_evt[1] = 1'b1; wr(2, 32'h0); tick();
    rd(2, d); chk("R4 event wins", d, 32'h0000_0002);

    // R7: error on ch6 without mask leaves summary clear
    err_evt[6*8 +: 8] = 8'h05; tick();
    rd(0, d); chk("R7 masked err", d[13], 1'b0);
    wr(16 + 6, 32'hFFFF_FFFF); tick();
    rd(0, d); chk("R7 unmasked err", {31'h0, d[13]}, 32'h1);
    // R6: all-zero write clears error cause
    wr(8 + 6, 32'h0); tick();
    rd(8 + 6, d); chk("R6 clear", d, 32'h0);

    // R10: write to main cause address is ignored
    wr(0, 32'hFFFF_FFFF); tick();
    rd(1, d); chk("R10 mask kept", d, 32'h0000_0010);

    // mixed traffic, full compare each edge
    wr(1, 32'hFFFF_FFFF); tick();
    for (int i = 0; i < 400; i++) begin
      done_evt = 8'($urandom) & 8'($urandom) & 8'($urandom);
      dev_evt  = 8'($urandom) & 8'($urandom) & 8'($urandom);
      err_evt  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      if ($urandom_range(0, 2) == 0) begin
        int a = $urandom_range(0, 23);
        wr(a, $urandom);
      end
      tick();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule